// File: doc/BRIEF.md
# YUV/YCbCr to RGB Converter

This block turns a stream of 8-bit luma and chroma samples into 8-bit red, green and blue values. Each accepted sample carries a mode bit that picks one of two programmable coefficient sets. One set is intended for full-range YUV and the other for video-range YCbCr. Both sets come up from reset holding usable presets. Software can overwrite any coefficient or offset in either set through a simple write port.

Both offsets are added to the inputs first. The shifted luma and chroma values are then multiplied by fixed-point coefficients. The products are summed per channel, rounded to the nearest integer and saturated to the pixel range. The arithmetic is:

- red = C0·(Y+Yofs) + C1·(V+Cofs)
- green = C0·(Y+Yofs) + C3·(U+Cofs) + C2·(V+Cofs)
- blue = C0·(Y+Yofs) + C4·(U+Cofs)

The block is a three-stage pipeline: offset add, multiply, then sum/round/clamp. It accepts one sample per clock. The valid flag travels alongside the data.

Top module: `yuv2rgb_conv`

## Requirements
- R1: While reset is held and once it has been released, `out_valid` is low and `out_r`, `out_g` and `out_b` are zero until the first result appears.
- R2: A sample accepted on a rising edge with `in_valid` high yields exactly one result, with `out_valid` high, three rising edges later. Results leave in the order their samples were accepted, and gaps in `in_valid` are reproduced at the output.
- R3: With `in_ycc`=0 and the reset presets, each channel follows the equations above using C0=0x100, C1=0x123, C2=0x76B, C3=0x79B, C4=0x208 and both offsets zero.
- R4: With `in_ycc`=1 and the reset presets, each channel uses C0=0x12A, C1=0x198, C2=0x730, C3=0x79C, C4=0x204, luma offset 0x1F0 (-16) and chroma offset 0x180 (-128).
- R5: Each channel sum carries 8 fraction bits. It is rounded by adding 0x80 and then shifting right arithmetically by 8 bits.
- R6: A rounded result below 0 is output as 0, and a rounded result above 255 is output as 255.
- R7: Coefficients are 11-bit two's complement values with 8 fraction bits. Offsets are 9-bit two's complement values taken from `cfg_wdata[8:0]`. A write with `cfg_we`=1 stores `cfg_wdata` into the set named by `cfg_bank` (0 is the YUV set, 1 is the YCbCr set). `cfg_addr` selects the field: 0..4 are C0..C4, 5 is the luma offset and 6 is the chroma offset. The new value is used for samples accepted on later edges.
- R8: A write changes only the addressed field of the addressed set. A write with `cfg_addr`=7 changes nothing.
- R9: While `out_valid` is low, `out_r`, `out_g` and `out_b` hold their previous values.
- R10: The mode bit is sampled together with each sample. Consecutive samples in different modes are each converted with their own coefficient set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_bank | input | 1 | Coefficient set to write: 0 YUV, 1 YCbCr |
| cfg_addr | input | 3 | Field: 0..4 C0..C4, 5 luma offset, 6 chroma offset, 7 none |
| cfg_wdata | input | 11 | Write value; offsets use bits 8:0 |
| in_valid | input | 1 | Input sample qualifier |
| in_ycc | input | 1 | Mode of this sample: 0 YUV, 1 YCbCr |
| in_y | input | 8 | Luma |
| in_u | input | 8 | Blue-difference chroma (U / Cb) |
| in_v | input | 8 | Red-difference chroma (V / Cr) |
| out_valid | output | 1 | Output result qualifier |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
A corrupted coefficient or offset register shows up at the ports three edges after the first sample that uses it. It appears only in the channels whose equation contains that field, so an error in the green-only terms C2 or C3 leaves red and blue correct. A stuck or mistimed valid stage appears as a missing, duplicated or early `out_valid`, which the bench detects on the same cycle. Dense sweeps of luma against chroma in both modes drive every channel across both saturation limits and the rounding boundary. Directed write sequences check that writes reach only the addressed field and set.

// File: rtl/yuvrgb_pkg.sv
package yuvrgb_pkg;

  localparam int NUM_COEF = 5;
  localparam int NUM_BANK = 2;

  typedef enum logic [2:0] {
    FLD_C0    = 3'd0,
    FLD_C1    = 3'd1,
    FLD_C2    = 3'd2,
    FLD_C3    = 3'd3,
    FLD_C4    = 3'd4,
    FLD_YOFS  = 3'd5,
    FLD_UVOFS = 3'd6,
    FLD_NONE  = 3'd7
  } cfg_field_e;

  // Reset presets as signed integers (fraction bits = 8)
  function automatic int preset_coef(int bank, int idx);
    int r;
    r = 0;
    if (bank == 0) begin
      case (idx)
        0: r = 256;
        1: r = 291;
        2: r = -149;
        3: r = -101;
        4: r = 520;
        default: r = 0;
      endcase
    end else begin
      case (idx)
        0: r = 298;
        1: r = 408;
        2: r = -208;
        3: r = -100;
        4: r = 516;
        default: r = 0;
      endcase
    end
    return r;
  endfunction

  function automatic int preset_yofs(int bank);
    return (bank == 0) ? 0 : -16;
  endfunction

  function automatic int preset_uvofs(int bank);
    return (bank == 0) ? 0 : -128;
  endfunction

endpackage

// File: rtl/yuvrgb_coef_bank.sv
module yuvrgb_coef_bank
  import yuvrgb_pkg::*;
#(
  parameter int COEF_W = 11,
  parameter int OFS_W  = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_bank,
  input  logic [2:0]               cfg_addr,
  input  logic [COEF_W-1:0]        cfg_wdata,
  input  logic                     sel_ycc,
  output logic signed [COEF_W-1:0] coef_o [NUM_COEF],
  output logic signed [OFS_W-1:0]  yofs_o,
  output logic signed [OFS_W-1:0]  uvofs_o
);

  localparam int FLAT_W = NUM_COEF * COEF_W + 2 * OFS_W;

  logic signed [COEF_W-1:0] coef_q  [NUM_BANK][NUM_COEF];
  logic signed [COEF_W-1:0] coef_d  [NUM_BANK][NUM_COEF];
  logic signed [OFS_W-1:0]  yofs_q  [NUM_BANK];
  logic signed [OFS_W-1:0]  yofs_d  [NUM_BANK];
  logic signed [OFS_W-1:0]  uvofs_q [NUM_BANK];
  logic signed [OFS_W-1:0]  uvofs_d [NUM_BANK];
  logic [FLAT_W-1:0]        flat    [NUM_BANK];

  // Next-state: a single field of a single set per write
  always_comb begin
    coef_d  = coef_q;
    yofs_d  = yofs_q;
    uvofs_d = uvofs_q;
    case (cfg_field_e'(cfg_addr))
      FLD_C0, FLD_C1, FLD_C2, FLD_C3, FLD_C4:
        coef_d[cfg_bank][cfg_addr] = cfg_wdata;
      FLD_YOFS:
        yofs_d[cfg_bank] = cfg_wdata[OFS_W-1:0];
      FLD_UVOFS:
        uvofs_d[cfg_bank] = cfg_wdata[OFS_W-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANK; b++) begin
        for (int i = 0; i < NUM_COEF; i++) begin
          coef_q[b][i] <= COEF_W'(preset_coef(b, i));
        end
        yofs_q[b]  <= OFS_W'(preset_yofs(b));
        uvofs_q[b] <= OFS_W'(preset_uvofs(b));
      end
    end else if (cfg_we) begin
      coef_q  <= coef_d;
      yofs_q  <= yofs_d;
      uvofs_q <= uvofs_d;
    end
  end

  // Read side: the set picked by the incoming sample's mode
  always_comb begin
    for (int i = 0; i < NUM_COEF; i++) begin
      coef_o[i] = coef_q[sel_ycc][i];
    end
    yofs_o  = yofs_q[sel_ycc];
    uvofs_o = uvofs_q[sel_ycc];
  end

  always_comb begin
    for (int b = 0; b < NUM_BANK; b++) begin
      for (int i = 0; i < NUM_COEF; i++) begin
        flat[b][i*COEF_W +: COEF_W] = coef_q[b][i];
      end
      flat[b][NUM_COEF*COEF_W +: OFS_W]         = yofs_q[b];
      flat[b][NUM_COEF*COEF_W + OFS_W +: OFS_W] = uvofs_q[b];
    end
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_keep
    // R8
    bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && (cfg_bank == 1'(b)) && (cfg_addr != 3'd7)) |=> $stable(flat[b]));
  end

endmodule

// File: rtl/yuvrgb_offset_stage.sv
module yuvrgb_offset_stage
  import yuvrgb_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 11,
  parameter int OFS_W  = 9,
  parameter int SUM_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [PIX_W-1:0]         in_y,
  input  logic [PIX_W-1:0]         in_u,
  input  logic [PIX_W-1:0]         in_v,
  input  logic signed [COEF_W-1:0] coef_i [NUM_COEF],
  input  logic signed [OFS_W-1:0]  yofs_i,
  input  logic signed [OFS_W-1:0]  uvofs_i,
  output logic                     s1_valid,
  output logic signed [SUM_W-1:0]  ys_o,
  output logic signed [SUM_W-1:0]  us_o,
  output logic signed [SUM_W-1:0]  vs_o,
  output logic signed [COEF_W-1:0] coef_o [NUM_COEF]
);

  localparam int ZEXT = SUM_W - PIX_W;
  localparam int SEXT = SUM_W - OFS_W;

  logic signed [SUM_W-1:0] yofs_x, uvofs_x;
  logic signed [SUM_W-1:0] ys_d, us_d, vs_d;

  always_comb begin
    yofs_x  = {{SEXT{yofs_i[OFS_W-1]}}, yofs_i};
    uvofs_x = {{SEXT{uvofs_i[OFS_W-1]}}, uvofs_i};
    ys_d    = $signed({{ZEXT{1'b0}}, in_y}) + yofs_x;
    us_d    = $signed({{ZEXT{1'b0}}, in_u}) + uvofs_x;
    vs_d    = $signed({{ZEXT{1'b0}}, in_v}) + uvofs_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ys_o <= '0;
      us_o <= '0;
      vs_o <= '0;
      for (int i = 0; i < NUM_COEF; i++) coef_o[i] <= '0;
    end else if (in_valid) begin
      ys_o <= ys_d;
      us_o <= us_d;
      vs_o <= vs_d;
      for (int i = 0; i < NUM_COEF; i++) coef_o[i] <= coef_i[i];
    end
  end

  // R2
  s1_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  // R2
  s1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !s1_valid);

endmodule

// File: rtl/yuvrgb_mult_stage.sv
module yuvrgb_mult_stage
  import yuvrgb_pkg::*;
#(
  parameter int COEF_W = 11,
  parameter int SUM_W  = 10,
  parameter int PROD_W = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  logic signed [SUM_W-1:0]  ys_i,
  input  logic signed [SUM_W-1:0]  us_i,
  input  logic signed [SUM_W-1:0]  vs_i,
  input  logic signed [COEF_W-1:0] coef_i [NUM_COEF],
  output logic                     s2_valid,
  output logic signed [PROD_W-1:0] prod_o [NUM_COEF]
);

  logic signed [SUM_W-1:0]  opnd   [NUM_COEF];
  logic signed [PROD_W-1:0] prod_d [NUM_COEF];

  // Operand per coefficient: C0 luma, C1/C2 red-difference, C3/C4 blue-difference
  for (genvar i = 0; i < NUM_COEF; i++) begin : g_mul
    if (i == 0) begin : g_luma
      assign opnd[i] = ys_i;
    end else if (i == 1 || i == 2) begin : g_vchroma
      assign opnd[i] = vs_i;
    end else begin : g_uchroma
      assign opnd[i] = us_i;
    end
    assign prod_d[i] = PROD_W'(coef_i[i]) * PROD_W'(opnd[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_COEF; i++) prod_o[i] <= '0;
    end else if (s1_valid) begin
      for (int i = 0; i < NUM_COEF; i++) prod_o[i] <= prod_d[i];
    end
  end

  // R2
  s2_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> s2_valid);
  // R2
  s2_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !s2_valid);

endmodule

// File: rtl/yuvrgb_sum_clamp.sv
module yuvrgb_sum_clamp
  import yuvrgb_pkg::*;
#(
  parameter int PROD_W = 21,
  parameter int ACC_W  = 23,
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s2_valid,
  input  logic signed [PROD_W-1:0] prod_i [NUM_COEF],
  output logic                     out_valid,
  output logic [PIX_W-1:0]         out_r,
  output logic [PIX_W-1:0]         out_g,
  output logic [PIX_W-1:0]         out_b
);

  localparam int NUM_CH = 3;
  localparam logic signed [ACC_W-1:0] RND     = ACC_W'(1 << (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] term [NUM_COEF];
  logic signed [ACC_W-1:0] acc  [NUM_CH];
  logic signed [ACC_W-1:0] shf  [NUM_CH];
  logic [PIX_W-1:0]        pix_d [NUM_CH];
  logic [PIX_W-1:0]        pix_q [NUM_CH];

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_ext
    assign term[i] = ACC_W'(prod_i[i]);
  end

  // Channel sums: red, green (two chroma terms), blue
  assign acc[0] = term[0] + term[1];
  assign acc[1] = term[0] + term[3] + term[2];
  assign acc[2] = term[0] + term[4];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign shf[c]   = (acc[c] + RND) >>> FRAC_W;
    assign pix_d[c] = (shf[c] < 0)       ? '0 :
                      (shf[c] > PIX_MAX) ? {PIX_W{1'b1}} :
                                           shf[c][PIX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pix_q[c] <= '0;
      end else if (s2_valid) begin
        pix_q[c] <= pix_d[c];
      end
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s2_valid |=> $stable(pix_q[c]));
    // R6
    clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && (shf[c] < 0)) |=> (pix_q[c] == '0));
    // R6
    clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && (shf[c] > PIX_MAX)) |=> (&pix_q[c]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= s2_valid;
    end
  end

  assign out_r = pix_q[0];
  assign out_g = pix_q[1];
  assign out_b = pix_q[2];

  // R2
  out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> out_valid);

endmodule

// File: rtl/yuv2rgb_conv.sv
module yuv2rgb_conv
  import yuvrgb_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 11,
  parameter int FRAC_W = 8,
  parameter int OFS_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_bank,
  input  logic [2:0]        cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata,
  input  logic              in_valid,
  input  logic              in_ycc,
  input  logic [PIX_W-1:0]  in_y,
  input  logic [PIX_W-1:0]  in_u,
  input  logic [PIX_W-1:0]  in_v,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);

  localparam int SUM_W  = ((PIX_W + 1 > OFS_W) ? PIX_W + 1 : OFS_W) + 1;
  localparam int PROD_W = COEF_W + SUM_W;
  localparam int ACC_W  = PROD_W + 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  logic signed [COEF_W-1:0] coef_sel [NUM_COEF];
  logic signed [OFS_W-1:0]  yofs_sel, uvofs_sel;

  logic                     s1_valid;
  logic signed [SUM_W-1:0]  ys, us, vs;
  logic signed [COEF_W-1:0] coef_s1 [NUM_COEF];

  logic                     s2_valid;
  logic signed [PROD_W-1:0] prod [NUM_COEF];

  yuvrgb_coef_bank #(.COEF_W(COEF_W), .OFS_W(OFS_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg_we    (cfg_we),
    .cfg_bank  (cfg_bank),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .sel_ycc   (in_ycc),
    .coef_o    (coef_sel),
    .yofs_o    (yofs_sel),
    .uvofs_o   (uvofs_sel)
  );

  yuvrgb_offset_stage #(
    .PIX_W(PIX_W), .COEF_W(COEF_W), .OFS_W(OFS_W), .SUM_W(SUM_W)
  ) u_ofs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .in_valid (in_valid),
    .in_y     (in_y),
    .in_u     (in_u),
    .in_v     (in_v),
    .coef_i   (coef_sel),
    .yofs_i   (yofs_sel),
    .uvofs_i  (uvofs_sel),
    .s1_valid (s1_valid),
    .ys_o     (ys),
    .us_o     (us),
    .vs_o     (vs),
    .coef_o   (coef_s1)
  );

  yuvrgb_mult_stage #(
    .COEF_W(COEF_W), .SUM_W(SUM_W), .PROD_W(PROD_W)
  ) u_mul (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .s1_valid (s1_valid),
    .ys_i     (ys),
    .us_i     (us),
    .vs_i     (vs),
    .coef_i   (coef_s1),
    .s2_valid (s2_valid),
    .prod_o   (prod)
  );

  yuvrgb_sum_clamp #(
    .PROD_W(PROD_W), .ACC_W(ACC_W), .PIX_W(PIX_W), .FRAC_W(FRAC_W)
  ) u_sum (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .s2_valid  (s2_valid),
    .prod_i    (prod),
    .out_valid (out_valid),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_core_n |-> !out_valid);

endmodule

// File: tb/yuv2rgb_conv_test.sv
module yuv2rgb_conv_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_bank;
  logic [2:0]  cfg_addr;
  logic [10:0] cfg_wdata;
  logic        in_valid;
  logic        in_ycc;
  logic [7:0]  in_y, in_u, in_v;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  yuv2rgb_conv uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
    .in_ycc(in_ycc), .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk, n_bad, cyc;
  bit    done;
  int    mc [2][5];
  int    myo [2];
  int    muv [2];
  int    exp_q [$];
  int    time_q [$];
  string tag_q [$];
  bit    have_last;
  int    last_rgb;
  logic [15:0] lfsr;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%06h expected=%06h", tag, what, act, expv);
    end
  endtask

  function automatic int sx(int v, int w);
    int m;
    m = v & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m = m - (1 << w);
    return m;
  endfunction

  function automatic int rc(int x);
    int s;
    s = (x + 128) >>> 8;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic int model(bit m, int y, int u, int v);
    int ys, us, vs, r, g, b;
    ys = y + myo[m];
    us = u + muv[m];
    vs = v + muv[m];
    r = rc(mc[m][0]*ys + mc[m][1]*vs);
    g = rc(mc[m][0]*ys + mc[m][3]*us + mc[m][2]*vs);
    b = rc(mc[m][0]*ys + mc[m][4]*us);
    return (r << 16) | (g << 8) | b;
  endfunction

  task automatic observe();
    int act, e, t;
    string tg;
    act = {8'd0, out_r, out_g, out_b};
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected result", act, 0);
      end else begin
        e  = exp_q.pop_front();
        t  = time_q.pop_front();
        tg = tag_q.pop_front();
        check(act == e, tg, "rgb", act, e);
        check((cyc - t) == 3, "R2", "latency", cyc - t, 3);
      end
      have_last = 1'b1;
      last_rgb  = act;
    end else if (have_last) begin
      check(act == last_rgb, "R9", "hold while idle", act, last_rgb);
    end
  endtask

  task automatic step(bit v, bit m, int y, int u, int vv, string tag);
    @(negedge clk);
    cyc++;
    observe();
    cfg_we   = 1'b0;
    in_valid = v;
    in_ycc   = m;
    in_y     = y[7:0];
    in_u     = u[7:0];
    in_v     = vv[7:0];
    if (v) begin
      exp_q.push_back(model(m, y & 255, u & 255, vv & 255));
      time_q.push_back(cyc);
      tag_q.push_back(tag);
    end
  endtask

  task automatic cfg_write(bit bank, int addr, int data);
    @(negedge clk);
    cyc++;
    observe();
    in_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_bank  = bank;
    cfg_addr  = addr[2:0];
    cfg_wdata = data[10:0];
    if (addr < 5)       mc[bank][addr] = sx(data, 11);
    else if (addr == 5) myo[bank] = sx(data, 9);
    else if (addr == 6) muv[bank] = sx(data, 9);
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 0, 0, 0, "R2");
  endtask

  task automatic sweep(bit m, int ystep, int cstep, string tag);
    for (int y = 0; y < 256; y += ystep)
      for (int u = 0; u < 256; u += cstep)
        for (int v = 0; v < 256; v += cstep)
          step(1'b1, m, y, u, v, tag);
    drain();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; done = 1'b0; have_last = 1'b0; last_rgb = 0;
    lfsr = 16'hACE1;
    // Presets from R3 (bank 0) and R4 (bank 1)
    mc[0][0] = 256; mc[0][1] = 291; mc[0][2] = sx(11'h76B, 11);
    mc[0][3] = sx(11'h79B, 11); mc[0][4] = 520;
    mc[1][0] = 298; mc[1][1] = 408; mc[1][2] = sx(11'h730, 11);
    mc[1][3] = sx(11'h79C, 11); mc[1][4] = 516;
    myo[0] = 0; muv[0] = 0; myo[1] = sx(9'h1F0, 9); muv[1] = sx(9'h180, 9);

    rst_n = 1'b0; cfg_we = 1'b0; cfg_bank = 1'b0; cfg_addr = 3'd0; cfg_wdata = '0;
    in_valid = 1'b0; in_ycc = 1'b0; in_y = '0; in_u = '0; in_v = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    check({out_r, out_g, out_b} == 24'd0, "R1", "rgb after reset",
          int'({out_r, out_g, out_b}), 0);

    // R2 single sample latency
    step(1'b1, 1'b0, 100, 50, 200, "R2");
    drain();

    // R3 YUV presets, R4 YCbCr presets
    sweep(1'b0, 5, 17, "R3");
    sweep(1'b1, 5, 17, "R4");

    // R6 saturation corners
    step(1'b1, 1'b1, 255, 255, 255, "R6");
    step(1'b1, 1'b1, 0, 0, 0, "R6");
    step(1'b1, 1'b0, 255, 0, 255, "R6");
    step(1'b1, 1'b0, 0, 255, 0, "R6");
    drain();

    // R10 alternating modes, R2 gapped valid
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], bit'(i & 1), int'(lfsr[15:8]), int'(lfsr[7:0]),
           int'(lfsr[11:4]), "R10");
    end
    drain();

    // R8 ignored field code and cross-set isolation
    cfg_write(1'b0, 7, 11'h7FF);
    cfg_write(1'b1, 0, 11'h080);
    for (int y = 0; y < 256; y += 15) step(1'b1, 1'b0, y, 255 - y, y, "R8");
    drain();
    for (int y = 0; y < 256; y += 15) step(1'b1, 1'b1, y, 128, 60, "R8");
    drain();

    // R7 reprogram set 1 with extreme values
    cfg_write(1'b1, 1, 11'h400);
    cfg_write(1'b1, 2, 11'h3FF);
    cfg_write(1'b1, 5, 11'h0FF);
    cfg_write(1'b1, 6, 11'h100);
    cfg_write(1'b1, 4, 11'h7F0);
    sweep(1'b1, 15, 51, "R7");
    // write then sample on the very next cycle
    cfg_write(1'b0, 0, 11'h200);
    step(1'b1, 1'b0, 60, 10, 10, "R7");
    drain();

    // R5 rounding: C0 = 0.5 and 0.75, other terms zero
    cfg_write(1'b0, 1, 0);
    cfg_write(1'b0, 2, 0);
    cfg_write(1'b0, 3, 0);
    cfg_write(1'b0, 4, 0);
    cfg_write(1'b0, 0, 11'h080);
    for (int y = 0; y < 256; y++) step(1'b1, 1'b0, y, 77, 33, "R5");
    drain();
    cfg_write(1'b0, 0, 11'h0C0);
    cfg_write(1'b0, 5, 9'h1FF);
    for (int y = 0; y < 256; y++) step(1'b1, 1'b0, y, 0, 0, "R5");
    drain();

    check(exp_q.size() == 0, "R2", "results outstanding", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule